// File: doc/BRIEF.md
# Masked Four-Lane Vector Arithmetic Unit

This unit performs element-wise integer arithmetic on a private file of eight vector registers. Each register holds up to 64 elements of 32 bits. Four lanes work side by side, and element i always belongs to lane i mod 4. One command therefore retires four elements per clock. A runtime length register limits every vector operation to elements 0 through length-1.

A 64-bit flag register, one bit per element, can gate write-back. A not-equal compare of two registers writes the flags. Any arithmetic command that has its masked bit set writes only those elements whose flag is 1.

Commands arrive on a single port and are taken only while the unit is idle. The unit raises busy while the lanes work and pulses done once the last group has been written. Two housekeeping commands share the same port: one sets the length and one stores a single element. A combinational debug port returns any element, the flags and the current length.

Top module: `vlane_alu`

## Requirements
- R1: The length register comes out of reset at 64. Command SET_LEN (opcode 7) loads it from cmd_scalar, and any value above 64 is clamped to 64. Vector commands change only elements whose index is below the length.
- R2: A vector command (opcodes 0 to 6) run with length N keeps busy high for max(1, ceil(N/4)) cycles. Commands 7 and 8 keep busy high for one cycle.
- R3: Opcodes 0, 1 and 2 write vd[i] = va[i]+vb[i], va[i]-vb[i] and the low 32 bits of va[i]*vb[i], all modulo 2^32.
- R4: Opcodes 3, 4 and 5 write vd[i] = va[i]+s, va[i]-s and va[i]*s, where s is cmd_scalar, with the same wrapping as R3.
- R5: Opcode 6 sets flag bit i to (va[i] != vb[i]) for every i below the length. Flag bits at or above the length keep their value. The masked bit has no effect on this opcode. The flags come out of reset as all ones.
- R6: When an arithmetic command (opcodes 0 to 5) has cmd_masked=1, element i of vd is written only if flag bit i is 1. Every other element keeps its old value.
- R7: A command is accepted when cmd_valid is high and busy is low. Busy rises in the next cycle. Done is a one-cycle pulse in the cycle after busy falls. A command offered while busy is high is dropped and changes nothing.
- R8: A vector command issued with length 0 finishes after one busy cycle and writes no element and no flag.
- R9: Opcode 8 stores cmd_scalar into element cmd_elem of register vd, regardless of the length and the mask. dbg_data returns element dbg_idx of register dbg_reg combinationally. All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 4 | Opcode: 0..2 vector-vector, 3..5 vector-scalar, 6 compare, 7 set length, 8 store element |
| cmd_vd | input | 3 | Destination register |
| cmd_va | input | 3 | First source register |
| cmd_vb | input | 3 | Second source register |
| cmd_elem | input | 6 | Element index for opcode 8 |
| cmd_scalar | input | 32 | Scalar operand, new length, or store data |
| cmd_masked | input | 1 | Gate write-back with the flags |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| dbg_reg | input | 3 | Debug register select |
| dbg_idx | input | 6 | Debug element select |
| dbg_data | output | 32 | Selected element |
| dbg_flags | output | 64 | Flag register |
| dbg_len | output | 7 | Length register |

## Verification
Two events can fall in the same cycle. One is a new command offered on the port while the last lane group writes back. The other is a command offered in the very cycle done pulses. The bench drives a store command at the port during the final busy cycle of a long operation and then reads the target element through the debug port, which must still hold its old value. It then offers a store on the done cycle itself and confirms that this one is accepted and written.

// File: rtl/vlane_alu.sv
module vlane_alu #(
  parameter int NREG  = 8,
  parameter int LANES = 4,
  parameter int MAXVL = 64,
  parameter int W     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic [3:0]                 cmd_op,
  input  logic [$clog2(NREG)-1:0]    cmd_vd,
  input  logic [$clog2(NREG)-1:0]    cmd_va,
  input  logic [$clog2(NREG)-1:0]    cmd_vb,
  input  logic [$clog2(MAXVL)-1:0]   cmd_elem,
  input  logic [W-1:0]               cmd_scalar,
  input  logic                       cmd_masked,
  output logic                       busy,
  output logic                       done,
  input  logic [$clog2(NREG)-1:0]    dbg_reg,
  input  logic [$clog2(MAXVL)-1:0]   dbg_idx,
  output logic [W-1:0]               dbg_data,
  output logic [MAXVL-1:0]           dbg_flags,
  output logic [$clog2(MAXVL):0]     dbg_len
);
  localparam int IW = $clog2(MAXVL);
  localparam int RW = $clog2(NREG);
  localparam int LW = $clog2(LANES);
  localparam int GW = IW - LW;
  localparam int VW = IW + 1;

  localparam logic [3:0] OP_ADDV = 4'd0, OP_SUBV = 4'd1, OP_MULV = 4'd2;
  localparam logic [3:0] OP_ADDS = 4'd3, OP_SUBS = 4'd4, OP_MULS = 4'd5;
  localparam logic [3:0] OP_CMPNE = 4'd6, OP_SETLEN = 4'd7, OP_PUT = 4'd8;

  logic [W-1:0]     vr [NREG][MAXVL];
  logic [MAXVL-1:0] flag;
  logic [VW-1:0]    vlen;
  logic             busy_q, done_q, m_q;
  logic [3:0]       op_q;
  logic [RW-1:0]    vd_q, va_q, vb_q;
  logic [IW-1:0]    el_q;
  logic [W-1:0]     s_q;
  logic [GW-1:0]    grp, lastg;

  wire accept = cmd_valid & ~busy_q;
  wire [VW:0] len_up = {1'b0, vlen} + (VW+1)'(LANES - 1);
  wire [GW-1:0] lastg_n = (vlen == '0) ? '0 : GW'((len_up >> LW) - 1'b1);
  wire is_arith = (op_q <= OP_MULS);
  wire is_scal  = (op_q >= OP_ADDS) && (op_q <= OP_MULS);

  logic [IW-1:0] eidx [LANES];
  logic [W-1:0]  lres [LANES];
  logic          lwr  [LANES];
  logic          lne  [LANES];
  logic          lin  [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [W-1:0] ea, eb;
    assign eidx[l] = {grp, LW'(l)};
    assign ea = vr[va_q][eidx[l]];
    assign eb = is_scal ? s_q : vr[vb_q][eidx[l]];
    assign lin[l] = ({1'b0, eidx[l]} < vlen);
    assign lne[l] = (ea != eb);
    assign lwr[l] = is_arith & lin[l] & (~m_q | flag[eidx[l]]);
    always_comb begin
      case (op_q)
        OP_SUBV, OP_SUBS: lres[l] = ea - eb;
        OP_MULV, OP_MULS: lres[l] = ea * eb;
        default:          lres[l] = ea + eb;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++)
        for (int e = 0; e < MAXVL; e++)
          vr[r][e] <= '0;
      flag   <= '1;
      vlen   <= VW'(MAXVL);
      busy_q <= 1'b0;
      done_q <= 1'b0;
      op_q   <= '0;
      vd_q   <= '0;
      va_q   <= '0;
      vb_q   <= '0;
      el_q   <= '0;
      s_q    <= '0;
      m_q    <= 1'b0;
      grp    <= '0;
      lastg  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        op_q   <= cmd_op;
        vd_q   <= cmd_vd;
        va_q   <= cmd_va;
        vb_q   <= cmd_vb;
        el_q   <= cmd_elem;
        s_q    <= cmd_scalar;
        m_q    <= cmd_masked;
        grp    <= '0;
        lastg  <= (cmd_op <= OP_CMPNE) ? lastg_n : '0;
      end else if (busy_q) begin
        for (int l = 0; l < LANES; l++) begin
          if (lwr[l]) vr[vd_q][eidx[l]] <= lres[l];
          if (op_q == OP_CMPNE && lin[l]) flag[eidx[l]] <= lne[l];
        end
        if (op_q == OP_SETLEN)
          vlen <= (s_q > W'(MAXVL)) ? VW'(MAXVL) : s_q[VW-1:0];
        if (op_q == OP_PUT)
          vr[vd_q][el_q] <= s_q;
        if (grp == lastg) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          grp <= grp + 1'b1;
        end
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign dbg_data  = vr[dbg_reg][dbg_idx];
  assign dbg_flags = flag;
  assign dbg_len   = vlen;
endmodule

// File: rtl/vlane_alu_chk.sv
module vlane_alu_chk #(
  parameter int VW    = 7,
  parameter int MAXVL = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [3:0]    cmd_op,
  input logic          busy,
  input logic          done,
  input logic [VW-1:0] vlen
);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> busy);

  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op <= 4'd6 && vlen == '0) |=> (busy ##1 (!busy && done)));

  // R1
  len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vlen <= VW'(MAXVL));
endmodule

bind vlane_alu vlane_alu_chk #(.VW($clog2(MAXVL)+1), .MAXVL(MAXVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .busy(busy), .done(done), .vlen(vlen)
);

// File: tb/vlane_alu_bench.sv
module vlane_alu_bench;
  localparam int CLK_P = 10;
  localparam int NV = 11;

  localparam logic [3:0] T_OP [NV] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd0, 4'd5, 4'd1, 4'd6};
  localparam logic [2:0] T_VD [NV] = '{3'd4, 3'd5, 3'd6, 3'd4, 3'd5, 3'd6, 3'd0, 3'd4, 3'd5, 3'd6, 3'd0};
  localparam logic [2:0] T_VA [NV] = '{3'd0, 3'd0, 3'd0, 3'd2, 3'd0, 3'd2, 3'd0, 3'd0, 3'd1, 3'd2, 3'd2};
  localparam logic [2:0] T_VB [NV] = '{3'd2, 3'd2, 3'd2, 3'd0, 3'd0, 3'd0, 3'd1, 3'd1, 3'd0, 3'd0, 3'd0};
  localparam logic [31:0] T_S [NV] = '{32'd0, 32'd0, 32'd0, 32'h10, 32'h10, 32'hFFFFFFFF,
                                        32'd0, 32'd0, 32'd3, 32'd0, 32'd0};
  localparam logic T_M [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam int T_L [NV] = '{64, 64, 37, 64, 1, 63, 64, 64, 23, 5, 20};

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_masked = 0;
  logic [3:0] cmd_op = 0;
  logic [2:0] cmd_vd = 0, cmd_va = 0, cmd_vb = 0, dbg_reg = 0;
  logic [5:0] cmd_elem = 0, dbg_idx = 0;
  logic [31:0] cmd_scalar = 0, dbg_data;
  logic busy, done;
  logic [63:0] dbg_flags;
  logic [6:0] dbg_len;

  vlane_alu u_vlane_alu (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_vd(cmd_vd), .cmd_va(cmd_va), .cmd_vb(cmd_vb), .cmd_elem(cmd_elem),
    .cmd_scalar(cmd_scalar), .cmd_masked(cmd_masked), .busy(busy), .done(done),
    .dbg_reg(dbg_reg), .dbg_idx(dbg_idx), .dbg_data(dbg_data),
    .dbg_flags(dbg_flags), .dbg_len(dbg_len)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] m_reg [8][64];
  logic [63:0] m_flag;
  int m_len;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  function automatic logic [31:0] f_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      4'd1, 4'd4: return a - b;
      4'd2, 4'd5: return a * b;
      default:    return a + b;
    endcase
  endfunction

  task automatic mapply(input logic [3:0] op, input logic [2:0] vd, va, vb,
                        input logic [31:0] s, input logic m, input logic [5:0] el);
    case (op)
      4'd7: m_len = (s > 64) ? 64 : int'(s);
      4'd8: m_reg[vd][el] = s;
      4'd6: for (int i = 0; i < m_len; i++) m_flag[i] = (m_reg[va][i] != m_reg[vb][i]);
      default:
        for (int i = 0; i < m_len; i++)
          if (!m || m_flag[i])
            m_reg[vd][i] = f_op(op, m_reg[va][i], (op >= 4'd3) ? s : m_reg[vb][i]);
    endcase
  endtask

  task automatic drive(input logic [3:0] op, input logic [2:0] vd, va, vb,
                       input logic [31:0] s, input logic m, input logic [5:0] el);
    cmd_valid = 1; cmd_op = op; cmd_vd = vd; cmd_va = va; cmd_vb = vb;
    cmd_scalar = s; cmd_masked = m; cmd_elem = el;
  endtask

  task automatic issue(input logic [3:0] op, input logic [2:0] vd, va, vb,
                       input logic [31:0] s, input logic m, input logic [5:0] el, output int cyc);
    @(negedge clk);
    drive(op, vd, va, vb, s, m, el);
    @(negedge clk);
    cmd_valid = 0;
    cyc = 0;
    while (!done) begin
      if (busy) cyc++;
      @(negedge clk);
    end
    mapply(op, vd, va, vb, s, m, el);
  endtask

  task automatic check_reg(input logic [2:0] r, input string tag);
    logic [31:0] a, e;
    int bad;
    bad = 0; a = 0; e = 0;
    for (int i = 0; i < 64; i++) begin
      dbg_reg = r; dbg_idx = 6'(i); #1;
      if (bad == 0 && dbg_data !== m_reg[r][i]) begin
        bad = 1; a = dbg_data; e = m_reg[r][i];
      end
    end
    check(tag, {32'd0, a}, {32'd0, e});
  endtask

  initial begin
    int cyc, expc;
    string tag;
    for (int r = 0; r < 8; r++) for (int i = 0; i < 64; i++) m_reg[r][i] = 0;
    m_flag = '1; m_len = 64;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R7 reset busy/done", {62'd0, busy, done}, 64'd0);
    check("R1 reset length", {57'd0, dbg_len}, 64'd64);
    check("R5 reset flags", dbg_flags, '1);
    check_reg(3'd3, "R9 reset register");

    for (int i = 0; i < 64; i++) begin
      issue(4'd8, 3'd0, 0, 0, 32'(i * 3 + 1), 0, 6'(i), cyc);
      issue(4'd8, 3'd1, 0, 0, (i % 3 == 0) ? 32'(i * 3 + 1) : 32'h80000000 + 32'(i * 7), 0, 6'(i), cyc);
      issue(4'd8, 3'd2, 0, 0, 32'hFFFF0000 + 32'(i) * 32'h01234567, 0, 6'(i), cyc);
    end
    check("R9 store timing", 64'(cyc), 64'd1);
    check_reg(3'd0, "R9 store v0");
    check_reg(3'd1, "R9 store v1");
    check_reg(3'd2, "R9 store v2");

    for (int v = 0; v < NV; v++) begin
      if (T_L[v] != m_len) begin
        issue(4'd7, 0, 0, 0, 32'(T_L[v]), 0, 0, cyc);
        check("R1 set length", {57'd0, dbg_len}, 64'(T_L[v]));
      end
      expc = (m_len == 0) ? 1 : (m_len + 3) / 4;
      issue(T_OP[v], T_VD[v], T_VA[v], T_VB[v], T_S[v], T_M[v], 0, cyc);
      tag = T_M[v] && T_OP[v] != 4'd6 ? "R6" : (T_OP[v] == 4'd6 ? "R5" : (T_OP[v] >= 4'd3 ? "R4" : "R3"));
      check($sformatf("R2 cycles vector %0d", v), 64'(cyc), 64'(expc));
      if (T_OP[v] == 4'd6) check($sformatf("%s flags vector %0d", tag, v), dbg_flags, m_flag);
      else check_reg(T_VD[v], $sformatf("%s result vector %0d R1", tag, v));
    end

    issue(4'd7, 0, 0, 0, 32'd0, 0, 0, cyc);
    issue(4'd0, 3'd7, 3'd0, 3'd2, 0, 0, 0, cyc);
    check("R8 zero-length cycles", 64'(cyc), 64'd1);
    check_reg(3'd7, "R8 zero-length writes nothing");
    issue(4'd6, 0, 3'd0, 3'd2, 0, 0, 0, cyc);
    check("R8 zero-length compare keeps flags", dbg_flags, m_flag);

    issue(4'd7, 0, 0, 0, 32'd100, 0, 0, cyc);
    check("R1 length clamp", {57'd0, dbg_len}, 64'd64);

    @(negedge clk);
    drive(4'd0, 3'd6, 3'd0, 3'd1, 0, 0, 0);
    @(negedge clk);
    cmd_valid = 0;
    repeat (15) @(negedge clk);
    drive(4'd8, 3'd7, 0, 0, 32'hDEADBEEF, 0, 6'd0);
    @(negedge clk);
    cmd_valid = 0;
    check("R7 done after last group", {63'd0, done}, 64'd1);
    mapply(4'd0, 3'd6, 3'd0, 3'd1, 0, 0, 0);
    check_reg(3'd7, "R7 command during busy dropped");
    check_reg(3'd6, "R3 add under collision");

    @(negedge clk);
    drive(4'd0, 3'd5, 3'd2, 3'd2, 0, 0, 0);
    @(negedge clk);
    cmd_valid = 0;
    while (!done) @(negedge clk);
    drive(4'd8, 3'd7, 0, 0, 32'hCAFE0001, 0, 6'd9);
    @(negedge clk);
    cmd_valid = 0;
    check("R7 accept on done cycle", {63'd0, busy}, 64'd1);
    @(negedge clk);
    mapply(4'd0, 3'd5, 3'd2, 3'd2, 0, 0, 0);
    mapply(4'd8, 3'd7, 0, 0, 32'hCAFE0001, 0, 6'd9);
    check_reg(3'd7, "R9 store accepted on done cycle");
    check_reg(3'd5, "R3 doubled vector");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule